// File: doc/BRIEF.md
# DMA channel control and status register block

This block holds the software-visible control state of a two-channel DMA engine: channel 0 transmits and channel 1 receives. Each channel owns a 48-byte window on a simple 32-bit register bus with a byte address, a write strobe and a read strobe. Inside that window sit a control word, a status word, a current-descriptor pointer, a tail-descriptor pointer and spare words that keep whatever was last written to them.

The block enforces the write rules of the control and status words. It passes run, soft-reset and transmit-start strobes to the descriptor datapath. It collects halted and idle indications from the datapath and completion, delay and error events from the coalescing logic, and it drives one level interrupt per channel. Status reads also carry the coalescing logic's live threshold and delay counts. The read data is combinational on the address. Every write and every read side effect takes effect on the clock edge at which the strobe is sampled.

Top module: `dma_csr`

## Requirements
- R1: The channel is bit 0 of (byte address / 48), so 0x00–0x2F is channel 0, 0x30–0x5F is channel 1 and 0x60–0x7F aliases channel 0. The word inside the window is (address mod 48) / 4: 0 is control, 1 is status, 2 is current descriptor and 4 is tail descriptor.
- R2: After rst_ni, control reads 0x00010000 (completion threshold 1 in bits 23:16), status reads 0x00000001 (halted) with zero count inputs, and run_o, soft_rst_o, tx_start_o and irq_o are all low.
- R3: A control write stores the written value with bit 1 (tail mode) forced to 1. run_o follows control bit 0.
- R4: A control write with bit 2 set, or any control write while bit 2 is already held, reinitialises the channel: control becomes 0x00010006 and status becomes 0x00000001. soft_rst_o follows bit 2 and run_o is low. A control read returns the word with bit 2 clear and clears bit 2 at that edge.
- R5: A control write with bit 0 set that does not reset the channel clears status bits 0 (halted) and 1 (idle).
- R6: Status bits 14:12 (completion, delay, error) are set by cmpl_evt_i, dly_evt_i and err_evt_i and cleared by writing 1. The other bits of status 15:0 take the written value, and a same-cycle event wins over a clear.
- R7: A status read returns the channel's thr_cnt_i byte in bits 23:16 and its dly_cnt_i byte in bits 31:24.
- R8: irq_o of a channel is high exactly when some status bit among 14:12 is set and the control bit at the same position is set.
- R9: A tail-descriptor write clears status bit 1. On channel 0 only, tx_start_o is high for the one cycle after that write's edge.
- R10: Current-descriptor, tail and unused words of a window read back the last value written.
- R11: halted_set_i and idle_set_i set status bit 0 and bit 1 of their channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W (7) | Byte address of the access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (needed for the reset-bit read side effect) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word |
| run_o | output | 2 | Run bit per channel |
| soft_rst_o | output | 2 | Held soft-reset bit per channel |
| tx_start_o | output | 1 | One-cycle start strobe to the transmit descriptor engine |
| halted_set_i | input | 2 | Datapath sets the halted bit per channel |
| idle_set_i | input | 2 | Datapath sets the idle bit per channel |
| cmpl_evt_i | input | 2 | Completion interrupt event per channel |
| dly_evt_i | input | 2 | Delay interrupt event per channel |
| err_evt_i | input | 2 | Error interrupt event per channel |
| thr_cnt_i | input | 16 | Remaining completion count, byte per channel (channel 0 low) |
| dly_cnt_i | input | 16 | Delay timer count, byte per channel (channel 0 low) |
| irq_o | output | 2 | Interrupt line per channel |

## Verification
The hardest state to reach is a soft reset held across later writes. In that state a control write with run set must still leave the channel stopped, and only a read of the control word may release it. The stimulus sets the reset bit on the receive channel after that channel has been running. It then writes run alone, checks that run stays low, and reads control to see the reset bit masked in the data and dropped at that edge. A second hard corner is the write-one-to-clear status: events are pulsed into two flags, one flag is cleared by a write while the other survives, and then plain status bits are written alongside.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int NCH       = 2;
  localparam int WIN_BYTES = 48;
  localparam int WORDS     = WIN_BYTES / 4;
  localparam int WORD_W    = $clog2(WORDS);
  localparam int STAT_W    = 16;
  localparam int CNT_W     = (32 - STAT_W) / 2;

  localparam int B_RUN  = 0;
  localparam int B_TAIL = 1;
  localparam int B_RST  = 2;
  localparam int B_HALT = 0;
  localparam int B_IDLE = 1;
  localparam int FLAG_LO = 12;
  localparam int NFLAG   = 3;

  localparam logic [WORD_W-1:0] W_CTRL = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_STAT = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_TAIL = WORD_W'(4);

  localparam logic [31:0] CTRL_HW   = 32'h0001_0000;
  localparam logic [31:0] CTRL_SOFT = 32'h0001_0006;
  localparam logic [STAT_W-1:0] STAT_INIT = STAT_W'(1);
  localparam logic [STAT_W-1:0] FLAG_MASK = STAT_W'(((1 << NFLAG) - 1) << FLAG_LO);

  function automatic logic chan_of(input int unsigned a);
    int unsigned q;
    q = a / WIN_BYTES;
    return q[0];
  endfunction

  function automatic logic [WORD_W-1:0] word_of(input int unsigned a);
    return WORD_W'((a % WIN_BYTES) >> 2);
  endfunction
endpackage

// File: rtl/dma_csr_dec.sv
module dma_csr_dec
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              chan_o,
  output logic [WORD_W-1:0] word_o
);
  assign chan_o = chan_of(32'(addr_i));
  assign word_o = word_of(32'(addr_i));
endmodule

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
#(
  parameter bit IS_TX = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [31:0]       wdata_i,
  input  logic              halt_set_i,
  input  logic              idle_set_i,
  input  logic [NFLAG-1:0]  evt_i,
  input  logic [CNT_W-1:0]  thr_cnt_i,
  input  logic [CNT_W-1:0]  dly_cnt_i,
  output logic [31:0]       rdata_o,
  output logic [31:0]       ctrl_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              start_o
);
  logic [31:0]       ctrl_q, ctrl_d, ctrl_wv;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic [31:0]       misc_q [2:WORDS-1];
  logic              start_q;

  // tail mode forced; a held reset bit survives the write
  assign ctrl_wv = wdata_i | (32'd1 << B_TAIL) | (ctrl_q & (32'd1 << B_RST));

  always_comb begin
    ctrl_d = ctrl_q;
    stat_d = stat_q;
    if (rd_i && word_i == W_CTRL) ctrl_d[B_RST] = 1'b0;
    if (wr_i) begin
      unique case (word_i)
        W_CTRL: begin
          if (ctrl_wv[B_RST]) begin
            ctrl_d = CTRL_SOFT;
            stat_d = STAT_INIT;
          end else begin
            ctrl_d = ctrl_wv;
            if (ctrl_wv[B_RUN]) begin
              stat_d[B_HALT] = 1'b0;
              stat_d[B_IDLE] = 1'b0;
            end
          end
        end
        W_STAT: stat_d = (wdata_i[STAT_W-1:0] & ~FLAG_MASK)
                       | (stat_q & FLAG_MASK & ~wdata_i[STAT_W-1:0]);
        W_TAIL: stat_d[B_IDLE] = 1'b0;
        default: ;
      endcase
    end
    // datapath and coalescing events win over same-cycle clears
    stat_d[B_HALT] = stat_d[B_HALT] | halt_set_i;
    stat_d[B_IDLE] = stat_d[B_IDLE] | idle_set_i;
    stat_d[FLAG_LO +: NFLAG] = stat_d[FLAG_LO +: NFLAG] | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_HW;
      stat_q  <= STAT_INIT;
      start_q <= 1'b0;
      for (int k = 2; k < WORDS; k++) misc_q[k] <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      stat_q  <= stat_d;
      start_q <= IS_TX && wr_i && (word_i == W_TAIL);
      for (int k = 2; k < WORDS; k++)
        if (wr_i && word_i == WORD_W'(k)) misc_q[k] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (word_i == W_CTRL)
      rdata_o = ctrl_q & ~(32'd1 << B_RST);
    else if (word_i == W_STAT)
      rdata_o = {dly_cnt_i, thr_cnt_i, stat_q};
    else
      for (int k = 2; k < WORDS; k++)
        if (word_i == WORD_W'(k)) rdata_o = misc_q[k];
  end

  assign ctrl_o  = ctrl_q;
  assign stat_o  = stat_q;
  assign start_o = start_q;
endmodule

// File: rtl/dma_csr.sv
module dma_csr
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  output logic [NCH-1:0]        run_o,
  output logic [NCH-1:0]        soft_rst_o,
  output logic                  tx_start_o,
  input  logic [NCH-1:0]        halted_set_i,
  input  logic [NCH-1:0]        idle_set_i,
  input  logic [NCH-1:0]        cmpl_evt_i,
  input  logic [NCH-1:0]        dly_evt_i,
  input  logic [NCH-1:0]        err_evt_i,
  input  logic [NCH*CNT_W-1:0]  thr_cnt_i,
  input  logic [NCH*CNT_W-1:0]  dly_cnt_i,
  output logic [NCH-1:0]        irq_o
);
  logic              sel;
  logic [WORD_W-1:0] word;
  logic [NCH-1:0][31:0]       ctrl_w;
  logic [NCH-1:0][STAT_W-1:0] stat_w;
  logic [31:0]       rd_w [NCH];
  logic [NCH-1:0]    start_w;
  logic              unused_start;

  dma_csr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .chan_o (sel),
    .word_o (word)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_csr_chan #(.IS_TX(c == 0)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_i && (sel == 1'(c))),
      .rd_i       (rd_i && (sel == 1'(c))),
      .word_i     (word),
      .wdata_i    (wdata_i),
      .halt_set_i (halted_set_i[c]),
      .idle_set_i (idle_set_i[c]),
      .evt_i      ({err_evt_i[c], dly_evt_i[c], cmpl_evt_i[c]}),
      .thr_cnt_i  (thr_cnt_i[c*CNT_W +: CNT_W]),
      .dly_cnt_i  (dly_cnt_i[c*CNT_W +: CNT_W]),
      .rdata_o    (rd_w[c]),
      .ctrl_o     (ctrl_w[c]),
      .stat_o     (stat_w[c]),
      .start_o    (start_w[c])
    );
    assign run_o[c]      = ctrl_w[c][B_RUN];
    assign soft_rst_o[c] = ctrl_w[c][B_RST];
    assign irq_o[c]      = |(stat_w[c][FLAG_LO +: NFLAG] & ctrl_w[c][FLAG_LO +: NFLAG]);
  end

  assign rdata_o      = rd_w[sel];
  assign tx_start_o   = start_w[0];
  assign unused_start = start_w[1];
endmodule

// File: rtl/dma_csr_chk.sv
module dma_csr_chk
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [ADDR_W-1:0]          addr_i,
  input logic                       wr_i,
  input logic                       rd_i,
  input logic [31:0]                wdata_i,
  input logic [NCH-1:0]             run_o,
  input logic [NCH-1:0]             soft_rst_o,
  input logic                       tx_start_o,
  input logic [NCH-1:0]             halted_set_i,
  input logic [NCH-1:0]             idle_set_i,
  input logic [NCH-1:0]             cmpl_evt_i,
  input logic [NCH-1:0][31:0]       ctrl_w,
  input logic [NCH-1:0][STAT_W-1:0] stat_w
);
  logic              c_sel;
  logic [WORD_W-1:0] c_word;
  assign c_sel  = chan_of(32'(addr_i));
  assign c_word = word_of(32'(addr_i));

  p_start_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(wr_i && !c_sel && c_word == W_TAIL));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    p_tail_forced_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && c_sel == 1'(c) && c_word == W_CTRL) |=> ctrl_w[c][B_TAIL]);

    p_reset_stops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      soft_rst_o[c] |-> !run_o[c]);

    p_read_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !wr_i && c_sel == 1'(c) && c_word == W_CTRL) |=> !soft_rst_o[c]);

    p_run_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && c_sel == 1'(c) && c_word == W_CTRL && wdata_i[B_RUN] && !wdata_i[B_RST]
       && !soft_rst_o[c] && !halted_set_i[c] && !idle_set_i[c])
      |=> (stat_w[c][B_HALT] == 1'b0 && stat_w[c][B_IDLE] == 1'b0));

    p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && c_sel == 1'(c) && c_word == W_STAT && wdata_i[FLAG_LO] && !cmpl_evt_i[c])
      |=> !stat_w[c][FLAG_LO]);
  end
endmodule

bind dma_csr dma_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .wr_i         (wr_i),
  .rd_i         (rd_i),
  .wdata_i      (wdata_i),
  .run_o        (run_o),
  .soft_rst_o   (soft_rst_o),
  .tx_start_o   (tx_start_o),
  .halted_set_i (halted_set_i),
  .idle_set_i   (idle_set_i),
  .cmpl_evt_i   (cmpl_evt_i),
  .ctrl_w       (ctrl_w),
  .stat_w       (stat_w)
);

// File: tb/dma_csr_test.sv
`timescale 1ns/1ps
module dma_csr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  run, srst, irq;
  logic        tx_start;
  logic [1:0]  halt_set = '0, idle_set = '0, cmpl = '0, dly = '0, err = '0;
  logic [15:0] thr_cnt = '0, dly_cnt = '0;
  int n_chk = 0, n_bad = 0;
  logic [31:0] d;

  always #2.5 clk = ~clk;

  dma_csr uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .run_o(run), .soft_rst_o(srst),
    .tx_start_o(tx_start), .halted_set_i(halt_set), .idle_set_i(idle_set),
    .cmpl_evt_i(cmpl), .dly_evt_i(dly), .err_evt_i(err),
    .thr_cnt_i(thr_cnt), .dly_cnt_i(dly_cnt), .irq_o(irq)
  );

  // {address, write data, expected read-back}
  localparam logic [71:0] TBL [8] = '{
    {8'h08, 32'hDEADBEE0, 32'hDEADBEE0},
    {8'h38, 32'h12345678, 32'h12345678},
    {8'h2C, 32'hA5A50001, 32'hA5A50001},
    {8'h5C, 32'h0F0F0F0F, 32'h0F0F0F0F},
    {8'h00, 32'h00007000, 32'h00007002},
    {8'h30, 32'h03005001, 32'h03005003},
    {8'h10, 32'h00000040, 32'h00000040},
    {8'h0C, 32'h13572468, 32'h13572468}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr_bus(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); addr = a[6:0]; wdata = v; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_bus(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a[6:0]; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    chk("R2 run", 32'(run), 0);
    chk("R2 soft_rst", 32'(srst), 0);
    chk("R2 irq", 32'(irq), 0);
    chk("R2 tx_start", 32'(tx_start), 0);
    rd_bus(8'h00, d); chk("R2 ctrl0", d, 32'h00010000);
    rd_bus(8'h04, d); chk("R2 stat0", d, 32'h00000001);
    rd_bus(8'h34, d); chk("R2 stat1", d, 32'h00000001);

    // R1/R3/R10 table
    for (int i = 0; i < 8; i++) begin
      wr_bus(TBL[i][71:64], TBL[i][63:32]);
      rd_bus(TBL[i][71:64], d);
      chk($sformatf("R1/R3/R10 table %0d", i), d, TBL[i][31:0]);
    end
    chk("R3 run follows bit0", 32'(run), 32'h2);

    // R7 live counters
    thr_cnt = 16'h0305; dly_cnt = 16'h0A0B;
    rd_bus(8'h04, d); chk("R7 stat0 counts", d, 32'h0B050001);
    rd_bus(8'h34, d); chk("R7 stat1 counts", d, 32'h0A030000);
    thr_cnt = '0; dly_cnt = '0;

    // R1 alias window
    wr_bus(8'h68, 32'h00000077);
    rd_bus(8'h08, d); chk("R1 alias", d, 32'h00000077);
    rd_bus(8'h38, d); chk("R1 ch1 untouched", d, 32'h12345678);

    // R11 idle set, R5 run clears
    @(negedge clk); idle_set = 2'b01; @(negedge clk); idle_set = '0;
    rd_bus(8'h04, d); chk("R11 idle set", d, 32'h00000003);
    wr_bus(8'h00, 32'h00000001);
    chk("R5 run_o", 32'(run[0]), 1);
    rd_bus(8'h04, d); chk("R5 halted/idle cleared", d, 32'h00000000);
    rd_bus(8'h00, d); chk("R3 ctrl0", d, 32'h00000003);
    @(negedge clk); halt_set = 2'b01; @(negedge clk); halt_set = '0;
    rd_bus(8'h04, d); chk("R11 halted set", d, 32'h00000001);

    // R6 write-one-to-clear
    @(negedge clk); cmpl = 2'b01; dly = 2'b01; @(negedge clk); cmpl = '0; dly = '0;
    rd_bus(8'h04, d); chk("R6 events set", d, 32'h00003001);
    wr_bus(8'h04, 32'h00001000);
    rd_bus(8'h04, d); chk("R6 clear one flag", d, 32'h00002000);
    wr_bus(8'h04, 32'h00002005);
    rd_bus(8'h04, d); chk("R6 plain bits written", d, 32'h00000005);

    // R8 interrupt enable
    @(negedge clk); err = 2'b01; @(negedge clk); err = '0;
    chk("R8 pending not enabled", 32'(irq), 0);
    wr_bus(8'h00, 32'h00004001);
    chk("R8 enabled", 32'(irq), 32'h1);
    wr_bus(8'h04, 32'h00004000);
    chk("R8 cleared", 32'(irq), 0);

    // R9 tail writes
    @(negedge clk); idle_set = 2'b11; @(negedge clk); idle_set = '0;
    wr_bus(8'h10, 32'h00000080);
    chk("R9 tx start pulse", 32'(tx_start), 1);
    @(negedge clk); chk("R9 pulse one cycle", 32'(tx_start), 0);
    rd_bus(8'h04, d); chk("R9 idle cleared ch0", d, 32'h00000000);
    wr_bus(8'h40, 32'h00000044);
    chk("R9 no start on rx", 32'(tx_start), 0);
    @(negedge clk); chk("R9 no start on rx later", 32'(tx_start), 0);
    rd_bus(8'h34, d); chk("R9 idle cleared ch1", d, 32'h00000000);
    rd_bus(8'h40, d); chk("R10 tail ch1", d, 32'h00000044);

    // R4 held soft reset
    wr_bus(8'h30, 32'h00000005);
    chk("R4 soft_rst high", 32'(srst), 32'h2);
    chk("R4 run low", 32'(run[1]), 0);
    rd_bus(8'h34, d); chk("R4 status reinit", d, 32'h00000001);
    wr_bus(8'h30, 32'h00000001);
    chk("R4 held through write", 32'(srst[1]), 1);
    chk("R4 run blocked", 32'(run[1]), 0);
    rd_bus(8'h30, d); chk("R4 read masks bit2", d, 32'h00010002);
    chk("R4 released by read", 32'(srst[1]), 0);
    wr_bus(8'h30, 32'h00000001);
    chk("R4 run after release", 32'(run[1]), 1);
    rd_bus(8'h34, d); chk("R5 ch1 cleared", d, 32'h00000000);

    summary();
    $finish;
  end
endmodule